// File: doc/BRIEF.md
# Register file ALU datapath

This block is the 16-bit execution datapath of a small processor core. It has eight general registers, two operand latches, a one-bit shifter on the second operand, a four-function ALU, and a result register with a zero status bit. The block makes no decisions of its own. A controller outside it drives every index, enable and select line, one clock cycle at a time.

A typical operation needs three rising edges. On the first edge a value is written into a register. On the second edge that register is read into the operand latches. On the third edge the ALU output is captured as the result and the zero bit is updated. The value written back to the register file can be either the external input word or the current result, so results can be chained without going outside the block. The second operand can also be replaced by a small unsigned constant taken from the low bits of the external input.

The general registers have no reset and are laid out so that a distributed or block memory can hold them. A synchronous reset clears only the operand and result registers.

Top module: `rf_alu_datapath`

## Requirements
- R1: The register file holds eight 16-bit entries. When `wr_en` is high, a rising edge writes entry `wr_idx`. The read port shows entry `rd_idx` at all times, and entries that were not written hold their values.
- R2: The write data is `ext_in` when `wb_sel_ext` is 1. When `wb_sel_ext` is 0 it is the value on `result` before the edge.
- R3: On a rising edge, operand latch A loads the read port when `ld_a` is high and operand latch B loads it when `ld_b` is high. A latch whose enable is low keeps its value.
- R4: `result` changes only on an edge where `ld_c` is high, and `zero_flag` changes only on an edge where `ld_s` is high. Otherwise each keeps its value.
- R5: `shift_op` selects the operation on B: 2'b00 passes B unchanged, 2'b01 shifts left by one with a zero fill, 2'b10 shifts right by one with a zero fill, and 2'b11 shifts right by one and copies bit 15 into bit 15.
- R6: When `op_a_zero` is 1, the left ALU operand is zero. When it is 0, the left operand is latch A.
- R7: When `op_b_imm` is 1, the right ALU operand is `ext_in[4:0]` zero-extended to 16 bits. When it is 0, the right operand is the shifted B.
- R8: `alu_op` selects the function: 2'b00 gives left plus right, 2'b01 gives left minus right, 2'b10 gives the bitwise AND, and 2'b11 gives the bitwise inverse of right. Sums and differences wrap modulo 2^16.
- R9: On an edge with `ld_s` high, `zero_flag` becomes 1 if the ALU output is all zeros and 0 otherwise.
- R10: A rising edge with `rst` high clears A, B and `result` to zero and sets `zero_flag` to 1. Register file contents are unaffected.
- R11: If a value is written with the same index on both ports and every enable is held high, its ALU result appears on `result` after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset for the operand and result registers |
| ext_in | input | 16 | External data word; also the source of the small constant |
| wr_idx | input | 3 | Register file write index |
| rd_idx | input | 3 | Register file read index |
| wr_en | input | 1 | Register file write enable |
| ld_a | input | 1 | Load enable, operand latch A |
| ld_b | input | 1 | Load enable, operand latch B |
| ld_c | input | 1 | Load enable, result register |
| ld_s | input | 1 | Load enable, zero status bit |
| op_a_zero | input | 1 | Forces the left ALU operand to zero |
| op_b_imm | input | 1 | Selects the zero-extended constant as the right ALU operand |
| wb_sel_ext | input | 1 | Write-back source: 1 selects the external word, 0 selects the result |
| shift_op | input | 2 | Shift code applied to B |
| alu_op | input | 2 | ALU function code |
| result | output | 16 | Result register |
| zero_flag | output | 1 | Zero status bit |

## Verification
Each three-edge sequence writes a fresh value to a different register and then combines it with one shift code and one ALU function. A wrong register index, a missing shift fill, or a swapped opcode therefore gives a value no other path could give. The first value 0x8004 is chosen so that the two right shifts give different results, and 0xFFFF with a constant of one checks that addition and subtraction wrap at 16 bits. Some sequences hold the load enables low or route the result back through the register file. These separate the hold and write-back behaviour from plain computation, and a read after reset shows that the register contents survived the reset.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef enum logic [1:0] {
    SH_PASS = 2'b00,
    SH_LSL  = 2'b01,
    SH_LSR  = 2'b10,
    SH_ASR  = 2'b11
  } shift_op_e;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_AND  = 2'b10,
    ALU_NOTB = 2'b11
  } alu_op_e;

endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  // No reset on the storage so it maps onto distributed memory.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  // Asynchronous read: the operand latches act as the read register.
  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/dp_ldreg.sv
module dp_ldreg #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (ld) begin
      q <= d;
    end
  end

endmodule

// File: rtl/dp_shifter.sv
module dp_shifter
  import dp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  shift_op_e         mode,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] lsl_v;
  logic [DATA_W-1:0] lsr_v;
  logic [DATA_W-1:0] asr_v;

  // Each output bit takes its neighbour. Only the edge bits differ by fill.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign lsl_v[i] = 1'b0;
    end else begin : g_lo_n
      assign lsl_v[i] = din[i-1];
    end
    if (i == DATA_W-1) begin : g_hi
      assign lsr_v[i] = 1'b0;
      assign asr_v[i] = din[i];
    end else begin : g_hi_n
      assign lsr_v[i] = din[i+1];
      assign asr_v[i] = din[i+1];
    end
  end

  always_comb begin
    unique case (mode)
      SH_PASS: dout = din;
      SH_LSL:  dout = lsl_v;
      SH_LSR:  dout = lsr_v;
      SH_ASR:  dout = asr_v;
      default: dout = din;
    endcase
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] y,
  output logic              y_zero
);

  logic [DATA_W-1:0] sum_v;
  logic [DATA_W-1:0] dif_v;

  assign sum_v = lhs + rhs;
  assign dif_v = lhs - rhs;

  always_comb begin
    unique case (op)
      ALU_ADD:  y = sum_v;
      ALU_SUB:  y = dif_v;
      ALU_AND:  y = lhs & rhs;
      ALU_NOTB: y = ~rhs;
      default:  y = sum_v;
    endcase
  end

  assign y_zero = (y == '0);

endmodule

// File: rtl/rf_alu_datapath.sv
module rf_alu_datapath
  import dp_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int IMM_W    = 5,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] ext_in,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic              ld_a,
  input  logic              ld_b,
  input  logic              ld_c,
  input  logic              ld_s,
  input  logic              op_a_zero,
  input  logic              op_b_imm,
  input  logic              wb_sel_ext,
  input  logic [1:0]        shift_op,
  input  logic [1:0]        alu_op,
  output logic [DATA_W-1:0] result,
  output logic              zero_flag
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] b_q;
  logic [DATA_W-1:0] b_shifted;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opnd_l;
  logic [DATA_W-1:0] opnd_r;
  logic [DATA_W-1:0] alu_y;
  logic              alu_zero;
  logic [DATA_W-1:0] c_q;
  logic              z_q;

  // Write-back source select
  assign wr_data = wb_sel_ext ? ext_in : c_q;

  dp_regfile #(.DATA_W(DATA_W), .DEPTH(NUM_REGS)) u_rf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  dp_ldreg #(.W(DATA_W)) u_areg (
    .clk (clk), .rst (rst), .ld (ld_a), .d (rd_data), .q (a_q)
  );

  dp_ldreg #(.W(DATA_W)) u_breg (
    .clk (clk), .rst (rst), .ld (ld_b), .d (rd_data), .q (b_q)
  );

  dp_shifter #(.DATA_W(DATA_W)) u_shift (
    .mode (shift_op_e'(shift_op)),
    .din  (b_q),
    .dout (b_shifted)
  );

  assign imm_ext = {{PAD_W{1'b0}}, ext_in[IMM_W-1:0]};
  assign opnd_l  = op_a_zero ? '0 : a_q;
  assign opnd_r  = op_b_imm ? imm_ext : b_shifted;

  dp_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (alu_op_e'(alu_op)),
    .lhs    (opnd_l),
    .rhs    (opnd_r),
    .y      (alu_y),
    .y_zero (alu_zero)
  );

  dp_ldreg #(.W(DATA_W)) u_creg (
    .clk (clk), .rst (rst), .ld (ld_c), .d (alu_y), .q (c_q)
  );

  dp_ldreg #(.W(1), .RST_VAL(1'b1)) u_sreg (
    .clk (clk), .rst (rst), .ld (ld_s), .d (alu_zero), .q (z_q)
  );

  assign result    = c_q;
  assign zero_flag = z_q;

endmodule

// File: rtl/dp_datapath_chk.sv
module dp_datapath_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_a,
  input logic              ld_c,
  input logic              ld_s,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] a_q,
  input logic [DATA_W-1:0] result,
  input logic              zero_flag
);

  p_a_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !ld_a |=> $stable(a_q));

  p_a_load_r3: assert property (@(posedge clk) disable iff (rst)
    ld_a |=> (a_q === $past(rd_data)));

  p_c_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !ld_c |=> $stable(result));

  p_z_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !ld_s |=> $stable(zero_flag));

  p_z_match_r9: assert property (@(posedge clk) disable iff (rst)
    (ld_c && ld_s) |=> (zero_flag == (result == '0)));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> ((result == '0) && zero_flag && (a_q == '0)));

endmodule

bind rf_alu_datapath dp_datapath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ld_a      (ld_a),
  .ld_c      (ld_c),
  .ld_s      (ld_s),
  .rd_data   (rd_data),
  .a_q       (a_q),
  .result    (result),
  .zero_flag (zero_flag)
);

// File: tb/rf_alu_datapath_test.sv
`timescale 1ns/1ps
module rf_alu_datapath_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] ext_in;
  logic [2:0]  wr_idx, rd_idx;
  logic        wr_en, ld_a, ld_b, ld_c, ld_s;
  logic        op_a_zero, op_b_imm, wb_sel_ext;
  logic [1:0]  shift_op, alu_op;
  logic [15:0] result;
  logic        zero_flag;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference model state with explicit "known" tracking
  logic [15:0] m_rf [8];
  bit          m_vld [8];
  logic [15:0] m_a, m_b, m_c;
  logic        m_z;
  bit          m_ak, m_bk, m_ck, m_zk;

  // Scoreboard queues
  logic [15:0] q_c [$];
  logic        q_z [$];
  bit          q_ck [$];
  bit          q_zk [$];
  string       q_tag [$];

  always #4 clk = ~clk;  // 125 MHz

  rf_alu_datapath uut (
    .clk(clk), .rst(rst), .ext_in(ext_in), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .wr_en(wr_en), .ld_a(ld_a), .ld_b(ld_b), .ld_c(ld_c), .ld_s(ld_s),
    .op_a_zero(op_a_zero), .op_b_imm(op_b_imm), .wb_sel_ext(wb_sel_ext),
    .shift_op(shift_op), .alu_op(alu_op), .result(result), .zero_flag(zero_flag)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // Driver: applies one cycle of inputs, updates the model, pushes expectations
  task automatic step(input bit r, input logic [15:0] x, input int wi, input int ri,
                      input bit we, input bit la, input bit lb, input bit lc, input bit ls,
                      input bit az, input bit bi, input bit wbx,
                      input logic [1:0] sh, input logic [1:0] op, input string tag);
    logic [15:0] rdv, shv, lv, rv, av, wd;
    bit rdk, lk, rk, avk, wdk;
    @(negedge clk);
    rst = r; ext_in = x; wr_idx = 3'(wi); rd_idx = 3'(ri);
    wr_en = we; ld_a = la; ld_b = lb; ld_c = lc; ld_s = ls;
    op_a_zero = az; op_b_imm = bi; wb_sel_ext = wbx; shift_op = sh; alu_op = op;
    @(posedge clk);
    rdv = m_rf[ri]; rdk = m_vld[ri];
    case (sh)
      2'b00: shv = m_b;
      2'b01: shv = {m_b[14:0], 1'b0};
      2'b10: shv = {1'b0, m_b[15:1]};
      default: shv = {m_b[15], m_b[15:1]};
    endcase
    lv = az ? 16'd0 : m_a;          lk = az | m_ak;
    rv = bi ? {11'd0, x[4:0]} : shv; rk = bi | m_bk;
    case (op)
      2'b00: av = lv + rv;
      2'b01: av = lv - rv;
      2'b10: av = lv & rv;
      default: av = ~rv;
    endcase
    avk = (op == 2'b11) ? rk : (lk & rk);
    wd = wbx ? x : m_c; wdk = wbx | m_ck;
    if (r) begin
      m_a = 16'd0; m_b = 16'd0; m_c = 16'd0; m_z = 1'b1;
      m_ak = 1; m_bk = 1; m_ck = 1; m_zk = 1;
    end else begin
      if (la) begin m_a = rdv; m_ak = rdk; end
      if (lb) begin m_b = rdv; m_bk = rdk; end
      if (lc) begin m_c = av; m_ck = avk; end
      if (ls) begin m_z = (av == 16'd0); m_zk = avk; end
    end
    if (we) begin m_rf[wi] = wd; m_vld[wi] = wdk; end
    q_c.push_back(m_c); q_z.push_back(m_z);
    q_ck.push_back(m_ck); q_zk.push_back(m_zk); q_tag.push_back(tag);
  endtask

  // Three edges with every enable high (write, load operands, load result)
  task automatic run3(input logic [15:0] x, input int idx, input bit az,
                      input bit wbx, input logic [1:0] sh, input logic [1:0] op,
                      input string tag);
    for (int k = 0; k < 3; k++)
      step(0, x, idx, idx, 1, 1, 1, 1, 1, az, 0, wbx, sh, op, tag);
  endtask

  // Monitor: compares outputs at the falling edge after each step
  initial begin
    forever begin
      @(negedge clk);
      if (q_c.size() > 0) begin
        logic [15:0] ec; logic ez; bit eck, ezk; string t;
        ec = q_c.pop_front(); ez = q_z.pop_front();
        eck = q_ck.pop_front(); ezk = q_zk.pop_front(); t = q_tag.pop_front();
        if (eck) begin
          n_vec++;
          if (result !== ec) begin
            n_bad++;
            $display("FAIL %s: result actual %h expected %h", t, result, ec);
          end
        end
        if (ezk) begin
          n_vec++;
          if (zero_flag !== ez) begin
            n_bad++;
            $display("FAIL %s: zero_flag actual %b expected %b", t, zero_flag, ez);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_rf[i] = 16'd0; m_vld[i] = 0; end
    m_a = 0; m_b = 0; m_c = 0; m_z = 0;
    m_ak = 0; m_bk = 0; m_ck = 0; m_zk = 0;
    rst = 1'b1; ext_in = 0; wr_idx = 0; rd_idx = 0; wr_en = 0;
    ld_a = 0; ld_b = 0; ld_c = 0; ld_s = 0;
    op_a_zero = 0; op_b_imm = 0; wb_sel_ext = 1; shift_op = 0; alu_op = 0;

    // R10: reset state, result 0 and zero flag 1
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00, "R10");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00, "R10");

    // R11 / R8 inverse: write 32, expect 0xFFDF on third edge
    run3(16'd32, 5, 0, 1, 2'b00, 2'b11, "R11");
    // R5 logical right then AND: 108 -> 36
    run3(16'd108, 7, 0, 1, 2'b10, 2'b10, "R5");
    // R6 left operand zero, R5 left shift, add: 6 -> 12
    run3(16'd6, 0, 1, 1, 2'b01, 2'b00, "R6");
    // R2 write-back of result into register 2, then subtract
    run3(16'd1, 2, 0, 0, 2'b10, 2'b01, "R2");
    // R9 subtract equal operands gives zero, flag 1
    run3(16'd99, 1, 0, 1, 2'b00, 2'b01, "R9");
    // R4 result and flag hold with loads low
    for (int k = 0; k < 3; k++)
      step(0, 16'd4, 2, 2, 1, 1, 1, 0, 0, 0, 0, 1, 2'b00, 2'b00, "R4");
    // R3 operand latches hold while register 2 (now 4) is on the read port
    step(0, 16'd0, 0, 2, 0, 0, 0, 1, 1, 0, 0, 1, 2'b00, 2'b00, "R3");
    step(0, 16'd0, 0, 2, 0, 0, 0, 1, 1, 0, 0, 1, 2'b00, 2'b00, "R3");
    // R1 distinct entries read back separately
    step(0, 16'h1111, 3, 0, 1, 0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00, "R1");
    step(0, 16'h2222, 4, 0, 1, 0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00, "R1");
    step(0, 16'h0, 0, 3, 0, 0, 1, 0, 0, 1, 0, 1, 2'b00, 2'b00, "R1");
    step(0, 16'h0, 0, 4, 0, 0, 0, 1, 1, 1, 0, 1, 2'b00, 2'b00, "R1");
    step(0, 16'h0, 0, 4, 0, 0, 1, 0, 0, 1, 0, 1, 2'b00, 2'b00, "R1");
    step(0, 16'h0, 0, 4, 0, 0, 0, 1, 1, 1, 0, 1, 2'b00, 2'b00, "R1");
    // R5 arithmetic right: 0x8004 -> 0xC002, then logical right -> 0x4002
    run3(16'h8004, 5, 1, 1, 2'b11, 2'b00, "R5");
    step(0, 16'h0, 0, 5, 0, 0, 0, 1, 1, 1, 0, 1, 2'b10, 2'b00, "R5");
    // R7 constant from low 5 bits of 0xFFF3 -> 0x0013
    step(0, 16'hFFF3, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 2'b00, 2'b00, "R7");
    // R8 wrap: 0xFFFF + 1 = 0, then 0 - 1 = 0xFFFF
    run3(16'hFFFF, 6, 0, 1, 2'b00, 2'b00, "R8");
    step(0, 16'h0001, 0, 6, 0, 0, 0, 1, 1, 0, 1, 1, 2'b00, 2'b00, "R8");
    step(0, 16'h0001, 0, 6, 0, 0, 0, 1, 1, 1, 1, 1, 2'b00, 2'b01, "R8");
    // R10 register file survives reset
    step(0, 16'h1234, 4, 0, 1, 0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00, "R10");
    step(1, 16'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00, "R10");
    step(0, 16'h0, 0, 4, 0, 0, 1, 0, 0, 1, 0, 1, 2'b00, 2'b00, "R10");
    step(0, 16'h0, 0, 4, 0, 0, 0, 1, 1, 1, 0, 1, 2'b00, 2'b11, "R10");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule